// File: doc/BRIEF.md
# PFC Fault and Soft-Start Sequencer

This block supervises a boost power-factor-correction stage from digital samples. Four analog quantities arrive as unsigned millivolt codes: the bias supply, the divided-down output sense, the magnitude of the (negative) current-sense voltage and the current-compensation node. From these it decides whether the converter may switch, and it steers a separate digital reference integrator (the voltage-loop compensation value) with three commands: clear, pre-charge and step.

A supply lockout with hysteresis keeps the stage off until the supply is high enough. Three further conditions (collapsed output sense, an open current-sense pin and a shorted compensation pin) force a common standby phase. In both cases switching stops and the integrator is cleared. Once every fault is gone, a soft start runs in three phases. First a fast pre-charge lifts the integrator to 1.5 V. Then a linear ramp adds a programmable step each clock until the output sense reaches 85 % of the 5 V reference. Then a tapered ramp at half that step runs until the output exceeds 98 %. At that point a done flag permits the fast dynamic-response mode of the loop.

Every comparator result passes a two-flop synchronizer. The fault and supply flags must also persist for four consecutive samples before they take effect.

Top module: `pfc_supervisor`

## Requirements
- R1: While reset is high and in the cycle after it, fault_stby_o=1, gate_en_o=0, vcomp_clr_o=1, vcomp_pre_o=0, vcomp_step_vld_o=0, vcomp_step_o=0 and ss_done_o=0.
- R2: The block leaves the off phase only when vcc_mv_i > 11500. Once out, it returns to the off phase only when vcc_mv_i <= 9500. Values in between keep the present phase.
- R3: With the supply good, vsense_mv_i < 820 forces standby, and 820 does not.
- R4: With the supply good, isense_mv_i > 85 (current-sense magnitude) forces standby, and 85 does not.
- R5: With the supply good, icomp_mv_i < 200 forces standby, and 200 does not.
- R6: In the off or standby phase, fault_stby_o=1, vcomp_clr_o=1 and gate_en_o=0. In every other phase, fault_stby_o=0 and gate_en_o=1.
- R7: A fault condition shorter than four consecutive clock samples has no effect on the outputs. A longer one forces standby.
- R8: After lockout and faults clear, vcomp_pre_o=1 until vcomp_mv_i >= 1500. The block then moves to the linear ramp.
- R9: In the linear ramp, vcomp_step_vld_o=1 and vcomp_step_o=ramp_step_i until vsense_mv_i >= 4250.
- R10: In the tapered ramp, vcomp_step_vld_o=1 and vcomp_step_o=floor(ramp_step_i/2). This lasts until vsense_mv_i > 4900, and 4900 itself keeps the taper.
- R11: After the taper ends, ss_done_o=1 and no integrator command is active. This holds, whatever the output sense does, until lockout or a fault.
- R12: At most one of vcomp_clr_o, vcomp_pre_o and vcomp_step_vld_o is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vcc_mv_i | input | 16 | Bias supply sample, mV |
| vsense_mv_i | input | 16 | Output sense sample, mV (5000 = rated) |
| isense_mv_i | input | 16 | Current-sense magnitude, mV |
| icomp_mv_i | input | 16 | Current-compensation node sample, mV |
| vcomp_mv_i | input | 16 | Present integrator value, mV |
| ramp_step_i | input | 12 | Integrator increment per clock in the linear ramp |
| fault_stby_o | output | 1 | Off or standby phase |
| gate_en_o | output | 1 | PWM switching permitted |
| ss_done_o | output | 1 | Soft start complete, fast response allowed |
| vcomp_clr_o | output | 1 | Command: clear integrator to zero |
| vcomp_pre_o | output | 1 | Command: fast pre-charge of integrator |
| vcomp_step_vld_o | output | 1 | Command: add vcomp_step_o this cycle |
| vcomp_step_o | output | 12 | Integrator increment |

## Verification
On every cycle, the assertions check the following. The integrator commands stay mutually exclusive. Lockout always coincides with the off phase. A filtered fault moves the sequencer to standby on the next edge. The ramp and done phases are entered only from their predecessor. A filtered flag rises only after its synchronized input has been true for consecutive samples. Other properties need the bench's scenarios. These are the hysteresis band, the exact threshold boundaries, rejection of a three-sample glitch, the halved taper step for odd step values, and the done phase persisting after the output sags.

// File: rtl/pfc_sup_pkg.sv
package pfc_sup_pkg;
  typedef enum logic [2:0] {
    PH_OFF   = 3'd0,
    PH_STBY  = 3'd1,
    PH_PRE   = 3'd2,
    PH_RAMP  = 3'd3,
    PH_TAPER = 3'd4,
    PH_RUN   = 3'd5
  } phase_e;
endpackage

// File: rtl/pfc_sup_filt.sv
module pfc_sup_filt #(
  parameter int N    = 5,
  parameter int FILT = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] raw_i,
  output logic [N-1:0] flt_o
);
  localparam int CNT_W = (FILT < 1) ? 1 : $clog2(FILT + 1);

  logic [N-1:0] s1_q, s2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= raw_i;
      s2_q <= s1_q;
    end
  end

  generate
    if (FILT == 0) begin : g_bypass
      assign flt_o = s2_q;
    end else begin : g_count
      for (genvar i = 0; i < N; i++) begin : g_bit
        logic [CNT_W-1:0] cnt_q;
        always_ff @(posedge clk) begin
          if (rst || !s2_q[i]) cnt_q <= '0;
          else if (cnt_q != CNT_W'(FILT)) cnt_q <= cnt_q + 1'b1;
        end
        assign flt_o[i] = (cnt_q == CNT_W'(FILT));

        assert_filt_hold_R7: assert property (@(posedge clk) disable iff (rst)
          $rose(flt_o[i]) |-> ($past(s2_q[i], 1) && $past(s2_q[i], 2)));
      end
    end
  endgenerate
endmodule

// File: rtl/pfc_sup_seq.sv
module pfc_sup_seq
  import pfc_sup_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   vcc_on_i,
  input  logic   vcc_off_i,
  input  logic   fault_i,
  input  logic   pre_ok_i,
  input  logic   ge85_i,
  input  logic   gt98_i,
  output phase_e phase_o
);
  logic   uvlo_q, uvlo_d;
  phase_e phase_q, phase_d;

  always_comb begin
    uvlo_d = uvlo_q;
    if (uvlo_q && vcc_on_i) uvlo_d = 1'b0;
    else if (!uvlo_q && vcc_off_i) uvlo_d = 1'b1;
  end

  always_comb begin
    phase_d = phase_q;
    if (uvlo_d) phase_d = PH_OFF;
    else if (fault_i) phase_d = PH_STBY;
    else begin
      case (phase_q)
        PH_OFF, PH_STBY: phase_d = PH_PRE;
        PH_PRE:   if (pre_ok_i) phase_d = PH_RAMP;
        PH_RAMP:  if (ge85_i)   phase_d = PH_TAPER;
        PH_TAPER: if (gt98_i)   phase_d = PH_RUN;
        default:  phase_d = phase_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      uvlo_q  <= 1'b1;
      phase_q <= PH_OFF;
    end else begin
      uvlo_q  <= uvlo_d;
      phase_q <= phase_d;
    end
  end

  assign phase_o = phase_q;

  assert_uvlo_off_R2: assert property (@(posedge clk) disable iff (rst)
    uvlo_q |-> (phase_q == PH_OFF));
  assert_fault_stby_R6: assert property (@(posedge clk) disable iff (rst)
    (!uvlo_d && fault_i) |=> (phase_q == PH_STBY));
  assert_ramp_entry_R8: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_RAMP && $past(phase_q) != PH_RAMP) |-> ($past(phase_q) == PH_PRE));
  assert_run_entry_R11: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_RUN && $past(phase_q) != PH_RUN) |-> ($past(phase_q) == PH_TAPER));
endmodule

// File: rtl/pfc_supervisor.sv
module pfc_supervisor
  import pfc_sup_pkg::*;
#(
  parameter int MV_W      = 16,
  parameter int STEP_W    = 12,
  parameter int FILT      = 4,
  parameter int VCC_ON    = 11500,
  parameter int VCC_OFF   = 9500,
  parameter int OLP_MV    = 820,
  parameter int ISOP_MV   = 85,
  parameter int ICMP_MV   = 200,
  parameter int PRE_MV    = 1500,
  parameter int VREF_MV   = 5000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MV_W-1:0]   vcc_mv_i,
  input  logic [MV_W-1:0]   vsense_mv_i,
  input  logic [MV_W-1:0]   isense_mv_i,
  input  logic [MV_W-1:0]   icomp_mv_i,
  input  logic [MV_W-1:0]   vcomp_mv_i,
  input  logic [STEP_W-1:0] ramp_step_i,
  output logic              fault_stby_o,
  output logic              gate_en_o,
  output logic              ss_done_o,
  output logic              vcomp_clr_o,
  output logic              vcomp_pre_o,
  output logic              vcomp_step_vld_o,
  output logic [STEP_W-1:0] vcomp_step_o
);
  localparam int TH85 = (VREF_MV * 85) / 100;
  localparam int TH98 = (VREF_MV * 98) / 100;

  logic [4:0] flt_raw, flt_q;
  logic [2:0] ss_raw, ss_q;
  phase_e     phase;

  assign flt_raw[0] = vcc_mv_i > MV_W'(VCC_ON);
  assign flt_raw[1] = vcc_mv_i <= MV_W'(VCC_OFF);
  assign flt_raw[2] = vsense_mv_i < MV_W'(OLP_MV);
  assign flt_raw[3] = isense_mv_i > MV_W'(ISOP_MV);
  assign flt_raw[4] = icomp_mv_i < MV_W'(ICMP_MV);

  assign ss_raw[0] = vcomp_mv_i >= MV_W'(PRE_MV);
  assign ss_raw[1] = vsense_mv_i >= MV_W'(TH85);
  assign ss_raw[2] = vsense_mv_i > MV_W'(TH98);

  pfc_sup_filt #(.N(5), .FILT(FILT)) u_fault_filt (
    .clk(clk), .rst(rst), .raw_i(flt_raw), .flt_o(flt_q)
  );

  pfc_sup_filt #(.N(3), .FILT(0)) u_ss_sync (
    .clk(clk), .rst(rst), .raw_i(ss_raw), .flt_o(ss_q)
  );

  pfc_sup_seq u_seq (
    .clk(clk), .rst(rst),
    .vcc_on_i(flt_q[0]), .vcc_off_i(flt_q[1]),
    .fault_i(|flt_q[4:2]),
    .pre_ok_i(ss_q[0]), .ge85_i(ss_q[1]), .gt98_i(ss_q[2]),
    .phase_o(phase)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fault_stby_o     <= 1'b1;
      gate_en_o        <= 1'b0;
      ss_done_o        <= 1'b0;
      vcomp_clr_o      <= 1'b1;
      vcomp_pre_o      <= 1'b0;
      vcomp_step_vld_o <= 1'b0;
      vcomp_step_o     <= '0;
    end else begin
      fault_stby_o     <= (phase == PH_OFF) || (phase == PH_STBY);
      gate_en_o        <= !((phase == PH_OFF) || (phase == PH_STBY));
      ss_done_o        <= (phase == PH_RUN);
      vcomp_clr_o      <= (phase == PH_OFF) || (phase == PH_STBY);
      vcomp_pre_o      <= (phase == PH_PRE);
      vcomp_step_vld_o <= (phase == PH_RAMP) || (phase == PH_TAPER);
      case (phase)
        PH_RAMP:  vcomp_step_o <= ramp_step_i;
        PH_TAPER: vcomp_step_o <= ramp_step_i >> 1;
        default:  vcomp_step_o <= '0;
      endcase
    end
  end

  assert_cmd_excl_R12: assert property (@(posedge clk) disable iff (rst)
    $onehot0({vcomp_clr_o, vcomp_pre_o, vcomp_step_vld_o}));
  assert_gate_clr_R6: assert property (@(posedge clk) disable iff (rst)
    vcomp_clr_o |-> (!gate_en_o && fault_stby_o));
  assert_done_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    ss_done_o |-> (!vcomp_step_vld_o && vcomp_step_o == '0));
endmodule

// File: tb/pfc_supervisor_tb.sv
module pfc_supervisor_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] vcc = 0, vs = 3000, is = 20, ic = 1000, vc = 0;
  logic [11:0] step = 12'd7;
  logic        fault_stby, gate_en, ss_done, clr, pre, vld;
  logic [11:0] step_o;

  int total = 0;
  int bad   = 0;
  bit over  = 0;
  int exp_ph = 0;   // 0 off,1 stby,2 pre,3 ramp,4 taper,5 run
  bit exp_uvlo = 1;

  always #2 clk = ~clk;

  pfc_supervisor dut_i (
    .clk(clk), .rst(rst), .vcc_mv_i(vcc), .vsense_mv_i(vs), .isense_mv_i(is),
    .icomp_mv_i(ic), .vcomp_mv_i(vc), .ramp_step_i(step),
    .fault_stby_o(fault_stby), .gate_en_o(gate_en), .ss_done_o(ss_done),
    .vcomp_clr_o(clr), .vcomp_pre_o(pre), .vcomp_step_vld_o(vld), .vcomp_step_o(step_o)
  );

  function automatic logic [17:0] exp_out(int ph, logic [11:0] st);
    case (ph)
      0, 1:    return {6'b100100, 12'd0};
      2:       return {6'b010010, 12'd0};
      3:       return {6'b010001, st};
      4:       return {6'b010001, st >> 1};
      default: return {6'b011000, 12'd0};
    endcase
  endfunction

  task automatic model();
    bit flt;
    if (exp_uvlo) exp_uvlo = !(vcc > 11500);
    else          exp_uvlo = (vcc <= 9500);
    flt = (vs < 820) || (is > 85) || (ic < 200);
    if (exp_uvlo) exp_ph = 0;
    else if (flt) exp_ph = 1;
    else begin
      if (exp_ph <= 1) exp_ph = 2;
      if (exp_ph == 2 && vc >= 1500) exp_ph = 3;
      if (exp_ph == 3 && vs >= 4250) exp_ph = 4;
      if (exp_ph == 4 && vs > 4900)  exp_ph = 5;
    end
  endtask

  task automatic check(string req);
    logic [17:0] act, exp;
    act = {fault_stby, gate_en, ss_done, clr, pre, vld, step_o};
    exp = exp_out(exp_ph, step);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic apply(string req);
    repeat (20) @(negedge clk);
    model();
    check(req);
  endtask

  task automatic finish_run();
    if (!over) begin
      over = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 in reset");
    rst = 0; vcc = 10500;
    @(negedge clk);
    check("R1 after reset");
    apply("R2 below on threshold stays off");
    vcc = 11500; apply("R2 at on threshold stays off");
    vcc = 12000; apply("R8 precharge after lockout");
    vcc = 10500; apply("R2 hysteresis band keeps running");
    vc = 1499;   apply("R8 below precharge level");
    vc = 1600;   apply("R9 linear ramp step");
    vs = 4249;   apply("R9 just below 85 percent");
    vs = 4250;   apply("R10 taper half step odd");
    vs = 4900;   apply("R10 4900 keeps taper");
    vs = 4901;   apply("R11 done above 98 percent");
    vs = 4500;   apply("R11 done holds after sag");
    // three-sample glitch on current sense
    is = 300; repeat (3) @(negedge clk); is = 20;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      total++;
      if (fault_stby !== 1'b0 || ss_done !== 1'b1) begin
        bad++;
        $display("FAIL R7 glitch: actual=%b%b expected=01", fault_stby, ss_done);
      end
    end
    is = 300; repeat (5) @(negedge clk); is = 20;
    repeat (1) @(negedge clk);
    model(); exp_ph = 1;
    repeat (3) @(negedge clk);
    check("R7 five-sample fault forces standby");
    is = 20;  apply("R8 recovery after standby");
    is = 86;  apply("R4 open current sense");
    is = 85;  apply("R4 85 is not a fault");
    ic = 199; apply("R5 shorted compensation");
    ic = 200; apply("R5 200 is not a fault");
    vs = 819; apply("R3 collapsed output");
    vs = 820; apply("R3 820 is not a fault");
    step = 12'd4095; apply("R9 max step");
    vcc = 9501; apply("R2 above off threshold");
    vcc = 9500; apply("R6 lockout clears and stops gate");
    for (int n = 0; n < 150; n++) begin
      vcc  = 16'(9000 + $urandom_range(4500));
      vs   = 16'($urandom_range(5500));
      is   = ($urandom_range(3) == 0) ? 16'($urandom_range(150)) : 16'($urandom_range(85));
      ic   = 16'(150 + $urandom_range(1850));
      vc   = 16'($urandom_range(3000));
      step = 12'($urandom_range(4095));
      apply("R12 random mix");
    end
    finish_run();
  end
endmodule